// File: doc/BRIEF.md
# Region-aware I/O port decoder

This block sits between a console CPU's 8-bit I/O port space and the peripherals around it: a programmable sound generator that is only written, a video controller with a data port, a control/status port and beam counters, a controller I/O chip with two pad ports, and an optional FM sound chip. Each port access is presented for one clock cycle with a read or write request. One clock later the block raises a registered one-cycle select strobe toward the peripheral it hits. For a read, it also places the merged read data on a registered output bus, which holds that value until the next read.

A region input picks between two decoding schemes. In the default scheme only address bits 7, 6 and 0 select a group, so every group is mirrored across the port space. In the Japanese scheme the upper group and the I/O-control group are decoded on all eight bits. That scheme also adds a 2-bit audio mixing register, which drives a mute output for the sound generator and a mute output for the FM chip. In the default scheme a read of the upper group may hit both the FM chip and a pad port. The two values are then combined by a bitwise AND.

Top module: `ioport_router`

## Requirements
- R1: The group of a write is chosen by port AND 0xC1. Value 0x40 or 0x41 pulses `psg_wr_o`, 0x80 pulses `vid_data_wr_o` and 0x81 pulses `vid_ctrl_wr_o`, in both regions.
- R2: The group of a read is chosen by port AND 0xC1. Value 0x40 returns `vcount_i` and 0x41 returns `hcount_i`, with no strobe. Value 0x80 returns `vid_data_i` and pulses `vid_data_rd_o`. Value 0x81 returns `vid_stat_i` and pulses `vid_ctrl_rd_o`.
- R3: Group 0x00/0x01 covers ports where port AND 0xC1 is 0x00 or 0x01. In the default region every write there pulses `ioctl_wr_o`. With `jp_mode`=1 only ports 0x3E and 0x3F do so, and the other ports are dropped. In both cases `dev_lsb_o` equals port bit 0.
- R4: Upper-group writes (port AND 0xC1 = 0xC0 or 0xC1) pulse `fm_wr_o`, with `dev_lsb_o` equal to port bit 0, under two conditions. With `jp_mode`=1 they do so only at ports 0xF0/0xF1 while `fm_en`=1. With `jp_mode`=0 they do so only while `fm_en`=1 and port bit 2 is 0.
- R5: With `jp_mode`=1 and `fm_en`=1, a write to port 0xF2 stores data bits 1:0 in the audio register. With `jp_mode`=1 a read of 0xF2 returns the stored bits in bits 1:0 and zero in bits 7:2, whatever the value of `fm_en`.
- R6: For audio value 00 the sound-generator mute `psg_mute_o` is 0 and the FM mute `fm_mute_o` is 1. Value 01 gives 1/0, value 10 gives 1/1 and value 11 gives 0/0. The mutes change only after a register write.
- R7: With `jp_mode`=1, reads of ports 0xC0, 0xC1, 0xDC and 0xDD return `pad_data_i` and pulse `pad_rd_o` (pad = port bit 0) when `io_off`=0. When `io_off`=1 they return 0xFF with no strobe.
- R8: With `jp_mode`=0, an upper-group read returns 0xFF ANDed with `fm_data_i` and with `pad_data_i`. The FM term applies, and `fm_rd_o` pulses, when `fm_en`=1 and port bit 2 is 0. The pad term applies, and `pad_rd_o` pulses, when `io_off`=0.
- R9: Writes to unused ports raise no strobe. Reads of unused ports return 0xFF. This includes every read of group 0x00/0x01 and Japanese-region upper-group reads outside 0xC0/0xC1/0xDC/0xDD/0xF2.
- R10: Strobes, `dev_lsb_o`, `wr_data_o` and `rd_data_o` are registered. They appear on the clock after the request, and strobes last one cycle. `rd_data_o` changes only on a read.
- R11: When `wr_en` and `rd_en` are both high, the write is decoded and the read is ignored: no read strobe is raised and `rd_data_o` holds its value.
- R12: A synchronous reset clears all strobes, sets `rd_data_o` to 0xFF and returns the audio register to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jp_mode | input | 1 | 1 selects full 8-bit Japanese-region decoding |
| fm_en | input | 1 | FM chip fitted and enabled |
| io_off | input | 1 | Pad ports disabled |
| port_addr | input | 8 | Port number of the access |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_data | input | DW | Write data |
| vcount_i | input | DW | Vertical beam counter |
| hcount_i | input | DW | Horizontal beam counter |
| vid_data_i | input | DW | Video data port read value |
| vid_stat_i | input | DW | Video status read value |
| fm_data_i | input | DW | FM chip read value |
| pad_data_i | input | DW | Selected pad port read value |
| psg_wr_o | output | 1 | Sound generator write strobe |
| vid_data_wr_o | output | 1 | Video data write strobe |
| vid_ctrl_wr_o | output | 1 | Video control write strobe |
| ioctl_wr_o | output | 1 | I/O control chip write strobe |
| fm_wr_o | output | 1 | FM chip write strobe |
| vid_data_rd_o | output | 1 | Video data read strobe |
| vid_ctrl_rd_o | output | 1 | Video status read strobe |
| fm_rd_o | output | 1 | FM chip read strobe |
| pad_rd_o | output | 1 | Pad port read strobe |
| dev_lsb_o | output | 1 | Port bit 0 of the access (register / pad select) |
| wr_data_o | output | DW | Registered write data |
| rd_data_o | output | DW | Merged read data |
| psg_mute_o | output | 1 | Sound generator mute |
| fm_mute_o | output | 1 | FM output mute |

## Verification
The two functions that can fall in the same cycle are the FM read and the pad read in the default region. One upper-group read then pulses `fm_rd_o` and `pad_rd_o` together and ANDs both values into `rd_data_o`. The bench drives distinct bit patterns on `fm_data_i` (0xF6) and `pad_data_i` (0x7B). It judges both strobes and the AND result 0x72, both in directed vectors and over a sweep of all 256 ports in both regions against a model. A second overlap is a request carrying both `wr_en` and `rd_en`. For that case the bench checks that only the write strobe appears and that the read bus keeps its previous value.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned AUD_W  = 2;

  localparam logic [PORT_W-1:0] GRP_MASK   = 8'hC1;
  localparam logic [PORT_W-1:0] P_FM0      = 8'hF0;
  localparam logic [PORT_W-1:0] P_FM1      = 8'hF1;
  localparam logic [PORT_W-1:0] P_AUDIO    = 8'hF2;
  localparam logic [PORT_W-2:0] P_IOC_HI   = 7'h1F;  // 0x3E / 0x3F
  localparam logic [PORT_W-2:0] P_PADA_HI  = 7'h60;  // 0xC0 / 0xC1
  localparam logic [PORT_W-2:0] P_PADB_HI  = 7'h6E;  // 0xDC / 0xDD

  typedef enum logic [2:0] {
    GRP_IOCTL,
    GRP_VCNT,
    GRP_HCNT,
    GRP_VDATA,
    GRP_VCTRL,
    GRP_UPPER
  } grp_e;

  typedef struct packed {
    logic psg_wr;
    logic vdat_wr;
    logic vctl_wr;
    logic ioc_wr;
    logic fm_wr;
    logic vdat_rd;
    logic vctl_rd;
    logic fm_rd;
    logic pad_rd;
  } strobe_t;

  function automatic grp_e port_group(input logic [PORT_W-1:0] p);
    logic [PORT_W-1:0] m;
    m = p & GRP_MASK;
    case (m)
      8'h00, 8'h01: return GRP_IOCTL;
      8'h40:        return GRP_VCNT;
      8'h41:        return GRP_HCNT;
      8'h80:        return GRP_VDATA;
      8'h81:        return GRP_VCTRL;
      default:      return GRP_UPPER;
    endcase
  endfunction

endpackage

// File: rtl/ioport_classify.sv
module ioport_classify
  import ioport_pkg::*;
(
  input  logic              jp_mode,
  input  logic              fm_en,
  input  logic              io_off,
  input  logic [PORT_W-1:0] port_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output grp_e              grp,
  output strobe_t           stb,
  output logic              aud_wr,
  output logic              aud_rd,
  output logic              rd_act
);

  logic wr_act;
  logic pad_hit;
  logic fm_port_jp;
  logic fm_port_def;

  assign wr_act      = wr_en;
  assign rd_act      = rd_en & ~wr_en;
  assign grp         = port_group(port_addr);
  assign pad_hit     = (port_addr[PORT_W-1:1] == P_PADA_HI) ||
                       (port_addr[PORT_W-1:1] == P_PADB_HI);
  assign fm_port_jp  = fm_en && ((port_addr == P_FM0) || (port_addr == P_FM1));
  assign fm_port_def = fm_en && !port_addr[2];

  always_comb begin
    stb    = '0;
    aud_wr = 1'b0;
    aud_rd = 1'b0;
    unique case (grp)
      GRP_IOCTL: begin
        if (wr_act)
          stb.ioc_wr = jp_mode ? (port_addr[PORT_W-1:1] == P_IOC_HI) : 1'b1;
      end
      GRP_VCNT, GRP_HCNT: begin
        stb.psg_wr = wr_act;
      end
      GRP_VDATA: begin
        stb.vdat_wr = wr_act;
        stb.vdat_rd = rd_act;
      end
      GRP_VCTRL: begin
        stb.vctl_wr = wr_act;
        stb.vctl_rd = rd_act;
      end
      default: begin
        if (jp_mode) begin
          stb.fm_wr  = wr_act && fm_port_jp;
          aud_wr     = wr_act && fm_en && (port_addr == P_AUDIO);
          aud_rd     = rd_act && (port_addr == P_AUDIO);
          stb.pad_rd = rd_act && pad_hit && !io_off;
        end else begin
          stb.fm_wr  = wr_act && fm_port_def;
          stb.fm_rd  = rd_act && fm_port_def;
          stb.pad_rd = rd_act && !io_off;
        end
      end
    endcase
  end

endmodule

// File: rtl/ioport_audio_ctl.sv
module ioport_audio_ctl
  import ioport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AUD_W-1:0] wdata,
  output logic [AUD_W-1:0] mix_q,
  output logic             psg_mute,
  output logic             fm_mute
);

  logic [AUD_W-1:0] mix_inc;

  always_ff @(posedge clk) begin
    if (rst)     mix_q <= '0;
    else if (wr) mix_q <= wdata;
  end

  // sound generator muted when (value + 1) has bit 1 set; FM muted when bit 0 clear
  assign mix_inc  = mix_q + 1'b1;
  assign psg_mute = mix_inc[1];
  assign fm_mute  = ~mix_q[0];

  p_mute_reset_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!psg_mute && fm_mute));

  p_mute_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr)) |-> ($stable(psg_mute) && $stable(fm_mute)));

  p_both_on_r6: assert property (@(posedge clk) disable iff (rst)
    (!psg_mute && !fm_mute) |-> (mix_q == 2'b11));

endmodule

// File: rtl/ioport_rdmux.sv
module ioport_rdmux
  import ioport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  grp_e             grp,
  input  strobe_t          stb,
  input  logic             aud_rd,
  input  logic [AUD_W-1:0] mix_q,
  input  logic [DW-1:0]    vcount_i,
  input  logic [DW-1:0]    hcount_i,
  input  logic [DW-1:0]    vid_data_i,
  input  logic [DW-1:0]    vid_stat_i,
  input  logic [DW-1:0]    fm_data_i,
  input  logic [DW-1:0]    pad_data_i,
  output logic [DW-1:0]    rd_value
);

  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] fm_term;
  logic [DW-1:0] pad_term;

  assign fm_term  = stb.fm_rd  ? fm_data_i  : ALL_ONES;
  assign pad_term = stb.pad_rd ? pad_data_i : ALL_ONES;

  always_comb begin
    unique case (grp)
      GRP_IOCTL: rd_value = ALL_ONES;
      GRP_VCNT:  rd_value = vcount_i;
      GRP_HCNT:  rd_value = hcount_i;
      GRP_VDATA: rd_value = vid_data_i;
      GRP_VCTRL: rd_value = vid_stat_i;
      default: begin
        if (aud_rd) rd_value = {{(DW-AUD_W){1'b0}}, mix_q};
        else        rd_value = ALL_ONES & fm_term & pad_term;
      end
    endcase
  end

endmodule

// File: rtl/ioport_router.sv
module ioport_router
  import ioport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jp_mode,
  input  logic          fm_en,
  input  logic          io_off,
  input  logic [7:0]    port_addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] vcount_i,
  input  logic [DW-1:0] hcount_i,
  input  logic [DW-1:0] vid_data_i,
  input  logic [DW-1:0] vid_stat_i,
  input  logic [DW-1:0] fm_data_i,
  input  logic [DW-1:0] pad_data_i,
  output logic          psg_wr_o,
  output logic          vid_data_wr_o,
  output logic          vid_ctrl_wr_o,
  output logic          ioctl_wr_o,
  output logic          fm_wr_o,
  output logic          vid_data_rd_o,
  output logic          vid_ctrl_rd_o,
  output logic          fm_rd_o,
  output logic          pad_rd_o,
  output logic          dev_lsb_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] rd_data_o,
  output logic          psg_mute_o,
  output logic          fm_mute_o
);

  grp_e             grp;
  strobe_t          stb_d;
  strobe_t          stb_q;
  logic             aud_wr;
  logic             aud_rd;
  logic             rd_act;
  logic [AUD_W-1:0] mix_q;
  logic [DW-1:0]    rd_value;

  ioport_classify u_classify (
    .jp_mode   (jp_mode),
    .fm_en     (fm_en),
    .io_off    (io_off),
    .port_addr (port_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .grp       (grp),
    .stb       (stb_d),
    .aud_wr    (aud_wr),
    .aud_rd    (aud_rd),
    .rd_act    (rd_act)
  );

  ioport_audio_ctl u_audio (
    .clk      (clk),
    .rst      (rst),
    .wr       (aud_wr),
    .wdata    (wr_data[AUD_W-1:0]),
    .mix_q    (mix_q),
    .psg_mute (psg_mute_o),
    .fm_mute  (fm_mute_o)
  );

  ioport_rdmux #(.DW(DW)) u_rdmux (
    .grp        (grp),
    .stb        (stb_d),
    .aud_rd     (aud_rd),
    .mix_q      (mix_q),
    .vcount_i   (vcount_i),
    .hcount_i   (hcount_i),
    .vid_data_i (vid_data_i),
    .vid_stat_i (vid_stat_i),
    .fm_data_i  (fm_data_i),
    .pad_data_i (pad_data_i),
    .rd_value   (rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q     <= '0;
      dev_lsb_o <= 1'b0;
      wr_data_o <= '0;
      rd_data_o <= '1;
    end else begin
      stb_q     <= stb_d;
      dev_lsb_o <= port_addr[0];
      if (wr_en)  wr_data_o <= wr_data;
      if (rd_act) rd_data_o <= rd_value;
    end
  end

  assign psg_wr_o      = stb_q.psg_wr;
  assign vid_data_wr_o = stb_q.vdat_wr;
  assign vid_ctrl_wr_o = stb_q.vctl_wr;
  assign ioctl_wr_o    = stb_q.ioc_wr;
  assign fm_wr_o       = stb_q.fm_wr;
  assign vid_data_rd_o = stb_q.vdat_rd;
  assign vid_ctrl_rd_o = stb_q.vctl_rd;
  assign fm_rd_o       = stb_q.fm_rd;
  assign pad_rd_o      = stb_q.pad_rd;

  p_ioctl_jp_r3: assert property (@(posedge clk) disable iff (rst)
    ioctl_wr_o |-> (!$past(jp_mode) || ($past(port_addr[7:1]) == 7'h1F)));

  p_psg_from_write_r1: assert property (@(posedge clk) disable iff (rst)
    psg_wr_o |-> ($past(wr_en) && (($past(port_addr) & 8'hC0) == 8'h40)));

  p_wr_beats_rd_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(rd_en)) |->
      (!vid_data_rd_o && !vid_ctrl_rd_o && !fm_rd_o && !pad_rd_o && $stable(rd_data_o)));

  p_audio_read_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && !$past(wr_en) && $past(jp_mode) &&
     ($past(port_addr) == 8'hF2)) |-> (rd_data_o[DW-1:AUD_W] == '0));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data_o));

  p_one_write_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({psg_wr_o, vid_data_wr_o, vid_ctrl_wr_o, ioctl_wr_o, fm_wr_o}));

endmodule

// File: tb/ioport_router_test.sv
`timescale 1ns/1ps
module ioport_router_test;

  localparam logic [7:0] VC  = 8'h5A;
  localparam logic [7:0] HC  = 8'hA3;
  localparam logic [7:0] VD  = 8'h3C;
  localparam logic [7:0] VS  = 8'hC9;
  localparam logic [7:0] FMD = 8'hF6;
  localparam logic [7:0] PAD = 8'h7B;

  // {jp, fm_en, io_off, wr, port, wdata, exp_rd, exp_psg_mute, exp_fm_mute}
  localparam int NVEC = 17;
  localparam logic [29:0] TBL [0:NVEC-1] = '{
    {1'b1,1'b1,1'b0,1'b1,8'hF2,8'h01,8'h00,1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b0,8'hF2,8'h00,8'h01,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b1,8'hF2,8'h03,8'h00,1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,8'hF2,8'h00,8'h01,1'b1,1'b0},
    {1'b0,1'b1,1'b0,1'b1,8'hF2,8'h02,8'h00,1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b1,8'hF2,8'h02,8'h00,1'b1,1'b1},
    {1'b1,1'b1,1'b0,1'b0,8'hF2,8'h00,8'h02,1'b1,1'b1},
    {1'b1,1'b1,1'b0,1'b1,8'hF2,8'h03,8'h00,1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b1,8'hF2,8'h00,8'h00,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b0,8'hDC,8'h00,8'hFF,1'b0,1'b1},
    {1'b0,1'b0,1'b1,1'b0,8'hDC,8'h00,8'hFF,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b0,8'hDD,8'h00,8'h7B,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b0,8'hF4,8'h00,8'hFF,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b0,8'hF0,8'h00,8'hF6,1'b0,1'b1},
    {1'b0,1'b1,1'b0,1'b0,8'hF0,8'h00,8'h72,1'b0,1'b1},
    {1'b1,1'b1,1'b0,1'b0,8'hF0,8'h00,8'hFF,1'b0,1'b1},
    {1'b1,1'b1,1'b0,1'b0,8'hC1,8'h00,8'h7B,1'b0,1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       jp_mode = 1'b0, fm_en = 1'b0, io_off = 1'b0;
  logic [7:0] port_addr = 8'h00;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       psg_wr, vdw, vcw, iow, fmw, vdr, vcr, fmr, padr, lsb;
  logic [7:0] wd_o, rd_o;
  logic       psgm, fmm;
  wire  [8:0] stb = {psg_wr, vdw, vcw, iow, fmw, vdr, vcr, fmr, padr};

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [1:0] mdl_mix = 2'b00;

  always #2.5 clk = ~clk;

  ioport_router #(.DW(8)) uut (
    .clk(clk), .rst(rst), .jp_mode(jp_mode), .fm_en(fm_en), .io_off(io_off),
    .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .vcount_i(VC), .hcount_i(HC), .vid_data_i(VD), .vid_stat_i(VS),
    .fm_data_i(FMD), .pad_data_i(PAD),
    .psg_wr_o(psg_wr), .vid_data_wr_o(vdw), .vid_ctrl_wr_o(vcw), .ioctl_wr_o(iow),
    .fm_wr_o(fmw), .vid_data_rd_o(vdr), .vid_ctrl_rd_o(vcr), .fm_rd_o(fmr),
    .pad_rd_o(padr), .dev_lsb_o(lsb), .wr_data_o(wd_o), .rd_data_o(rd_o),
    .psg_mute_o(psgm), .fm_mute_o(fmm)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // drive one request at a falling edge; returns at the next falling edge,
  // after the registered outputs have taken the result
  task automatic do_op(input bit jp, input bit fm, input bit io, input logic [7:0] p,
                       input bit w, input bit r, input logic [7:0] d);
    @(negedge clk);
    jp_mode = jp; fm_en = fm; io_off = io; port_addr = p;
    wr_en = w; rd_en = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // expectation from the requirements
  task automatic ref_model(input bit jp, input bit fm, input bit io, input logic [7:0] p,
                           input bit w, output logic [8:0] s, output logic [7:0] r);
    logic [7:0] g;
    logic pad_port;
    g = p & 8'hC1;
    s = '0;
    r = 8'hFF;
    pad_port = (p == 8'hC0) || (p == 8'hC1) || (p == 8'hDC) || (p == 8'hDD);
    if (w) begin
      if (g == 8'h40 || g == 8'h41) s[8] = 1'b1;                      // R1
      else if (g == 8'h80) s[7] = 1'b1;
      else if (g == 8'h81) s[6] = 1'b1;
      else if (g == 8'h00 || g == 8'h01)
        s[5] = jp ? (p == 8'h3E || p == 8'h3F) : 1'b1;                // R3
      else if (jp) s[4] = fm && (p == 8'hF0 || p == 8'hF1);           // R4
      else s[4] = fm && !p[2];
    end else begin
      if (g == 8'h40) r = VC;                                         // R2
      else if (g == 8'h41) r = HC;
      else if (g == 8'h80) begin s[3] = 1'b1; r = VD; end
      else if (g == 8'h81) begin s[2] = 1'b1; r = VS; end
      else if (g == 8'h00 || g == 8'h01) r = 8'hFF;                   // R9
      else if (jp) begin
        if (p == 8'hF2) r = {6'b0, mdl_mix};                          // R5
        else if (pad_port && !io) begin s[0] = 1'b1; r = PAD; end     // R7
      end else begin                                                  // R8
        if (fm && !p[2]) begin s[1] = 1'b1; r = r & FMD; end
        if (!io) begin s[0] = 1'b1; r = r & PAD; end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      finish_run();
    end
  end

  initial begin
    logic [8:0] es;
    logic [7:0] er;
    logic [7:0] prev;

    repeat (3) @(negedge clk);
    // R12: reset state
    check(stb == 9'h0, "R12 strobes", {7'h0, stb}, 16'h0);
    check(rd_o == 8'hFF, "R12 rd_data", {8'h0, rd_o}, 16'h00FF);
    check(!psgm && fmm, "R12 mutes", {14'h0, psgm, fmm}, 16'h0001);
    rst = 1'b0;
    @(negedge clk);

    // table walk: audio register, mute encodings, pad/FM merges (R5 R6 R7 R8 R9)
    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      v = TBL[i];
      do_op(v[29], v[28], v[27], v[25:18], v[26], !v[26], v[17:10]);
      if (!v[26]) check(rd_o == v[9:2], "R5/R7/R8 table read", {8'h0, rd_o}, {8'h0, v[9:2]});
      check({psgm, fmm} == v[1:0], "R6 table mutes", {14'h0, psgm, fmm}, {14'h0, v[1:0]});
    end
    mdl_mix = 2'b00;

    // full sweep in both regions against the model (R1 R2 R3 R4 R7 R8 R9 R10)
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 256; p++) begin
        for (int op = 0; op < 2; op++) begin
          logic [7:0] pp;
          logic [7:0] dd;
          pp = p[7:0];
          dd = pp ^ 8'h5A;
          ref_model(m[0], 1'b1, 1'b0, pp, op == 0, es, er);
          do_op(m[0], 1'b1, 1'b0, pp, op == 0, op == 1, dd);
          if (op == 0 && m == 1 && pp == 8'hF2) mdl_mix = dd[1:0];
          check(stb == es, "R1/R3/R4/R9 sweep strobes", {7'h0, stb}, {7'h0, es});
          if ((es[5] | es[4] | es[1] | es[0]) == 1'b1)
            check(lsb == pp[0], "R3/R4 sweep lsb", {15'h0, lsb}, {15'h0, pp[0]});
          if (op == 1) check(rd_o == er, "R2/R8/R9 sweep read", {8'h0, rd_o}, {8'h0, er});
          else check(wd_o == dd, "R10 sweep wdata", {8'h0, wd_o}, {8'h0, dd});
          check({psgm, fmm} == {(mdl_mix == 2'b01 || mdl_mix == 2'b10),
                                (mdl_mix == 2'b00 || mdl_mix == 2'b10)},
                "R6 sweep mutes", {14'h0, psgm, fmm}, {14'h0, mdl_mix});
        end
      end
    end

    // R10: strobe lasts one cycle, read data holds
    do_op(1'b0, 1'b1, 1'b0, 8'h40, 1'b0, 1'b1, 8'h00);
    check(rd_o == VC, "R10 read", {8'h0, rd_o}, {8'h0, VC});
    do_op(1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 8'h11);
    check(vdw, "R10 write strobe", {15'h0, vdw}, 16'h1);
    @(negedge clk);
    check(stb == 9'h0, "R10 strobe width", {7'h0, stb}, 16'h0);
    check(rd_o == VC, "R10 read hold", {8'h0, rd_o}, {8'h0, VC});

    // R11: simultaneous write and read at the video data port
    prev = rd_o;
    do_op(1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b1, 8'h22);
    check(stb == 9'b010000000, "R11 write only", {7'h0, stb}, 16'h0080);
    check(rd_o == prev, "R11 read ignored", {8'h0, rd_o}, {8'h0, prev});

    // R12: reset mid-run clears the audio register and read bus
    do_op(1'b1, 1'b1, 1'b0, 8'hF2, 1'b1, 1'b0, 8'h02);
    check(psgm && fmm, "R6 value 10", {14'h0, psgm, fmm}, 16'h0003);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!psgm && fmm && rd_o == 8'hFF, "R12 reset again", {6'h0, psgm, fmm, rd_o}, 16'h01FF);
    do_op(1'b1, 1'b0, 1'b0, 8'hF2, 1'b0, 1'b1, 8'h00);
    check(rd_o == 8'h00, "R12 audio readback", {8'h0, rd_o}, 16'h0);

    done = 1'b1;
    finish_run();
  end

endmodule